// File: doc/BRIEF.md
# Clear-Only Interrupt-Pending Register Unit

This unit holds the sticky pending flags of a processor's fast interrupt channels and the trigger-module "hit" flag. Both kinds of flag are raised only by hardware and can only be lowered by software. The flags sit in the upper half of a machine-level status register; the hit flag occupies one bit of the trigger-control register. The unit also contains the small arithmetic stage that all atomic register accesses share. That stage picks a register or immediate operand, forms an update mask and produces the read-modify-write result for the three access kinds: replace, set bits and clear bits.

An access arrives as a 3-bit command, a 12-bit register address, a register operand, a 5-bit immediate and a write strobe. The strobe is captured in a register and is dropped when the instruction was found to be illegal. In the cycle after capture, each flag is lowered where the captured mask holds a zero. This happens only for replace or clear commands aimed at that flag's register. A set command, or a replace with ones, can therefore never raise a flag. A hardware request always takes precedence over a software clear landing in the same cycle.

Top module: `pend_csr_unit`

## Requirements
- R1: Reset (rst_ni low) clears all pending flags and the hit flag, and both register read values are zero.
- R2: Command bit 2 selects the operand. A value of 1 selects the 5-bit immediate, zero-extended. A value of 0 selects the register operand. With an immediate, the upper half of the mask is zero for replace commands (code 101 clears every flag) and all ones for clear commands (code 111 leaves every flag).
- R3: Command bits 1:0 select the result on wdata_o. Code 01 returns the mask. Code 10 returns the old value OR the mask. Code 11 returns the old value AND the mask, where the mask is the inverted operand. Code 00 returns the mask. The old value is rdata_o for the presented address.
- R4: A high request on irq_req_i[i] sets pending flag i, which appears at rdata_o bit 16+i and pend_o[i] one clock later and stays set until cleared.
- R5: A replace command (bit 0 = 1, bit 1 = 0) at the pending address lowers each flag whose operand bit is 0 and leaves each flag whose operand bit is 1. The change is visible two clock edges after the strobe is presented.
- R6: Commands with bit 0 equal to 0 (set, and codes 000 and 100) never change any flag.
- R7: A clear command (bits 1:0 = 11) at the pending address lowers exactly the flags whose operand bit is 1.
- R8: When a request arrives in the same cycle as a software clear of its flag, the flag ends set.
- R9: A strobe presented together with illegal_i high changes no flag.
- R10: Accesses to any address other than the pending address (12'h344) or the trigger address (12'h7A1) change no flag and read zero. Pending-register bits 15:0 always read zero.
- R11: The hit flag (trigger register bit 22) is set when bp_match_i and bp_exc_i are both high. A replace or clear command at the trigger address lowers it when mask bit 22 is 0. A set request in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Register write strobe from decode |
| illegal_i | input | 1 | Current instruction flagged illegal |
| cmd_i | input | 3 | Access command: bit 2 operand source, bits 1:0 operation |
| addr_i | input | 12 | Register address of the access |
| rs1_i | input | 32 | Register operand |
| uimm_i | input | 5 | Immediate operand |
| irq_req_i | input | 16 | Hardware interrupt request lines |
| bp_match_i | input | 1 | Trigger address match |
| bp_exc_i | input | 1 | Breakpoint exception pending |
| rdata_o | output | 32 | Read value of the addressed register |
| wdata_o | output | 32 | Read-modify-write result |
| pend_o | output | 16 | Pending flags |
| hit_o | output | 1 | Trigger hit flag |

## Verification
The bench sweeps all eight command codes over several operand and preset-flag patterns at the pending address, and predicts both the ALU result and the surviving flags. A design that reused the combined result instead of the mask would let a set or replace-with-ones raise flags, and a design that ignored command bit 0 would let set commands clear flags. The bench also targets the request-versus-clear collision, which a clear-first design loses. It covers the immediate replace that wipes every flag through zero-extension, the illegal-instruction suppression, which a design missing it would turn into a spurious clear, and the hit flag's separate address and bit position.

// File: rtl/pend_csr_pkg.sv
package pend_csr_pkg;

   // operation field of an atomic register access (command bits 1:0)
   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_WRITE = 2'b01,
      OP_SET   = 2'b10,
      OP_CLEAR = 2'b11
   } csr_op_e;

   // full command: bit 2 chooses the immediate operand
   typedef struct packed {
      logic    src_imm;
      csr_op_e op;
   } csr_cmd_t;

   // replace and clear may lower clear-only flags; set and none may not
   function automatic logic op_lowers(input csr_op_e op);
      return op[0];
   endfunction

endpackage

// File: rtl/pend_csr_alu.sv
module pend_csr_alu
   import pend_csr_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int IMM_W    = 5,
   parameter int PEND_LSB = 16,
   parameter int NCH      = 16,
   parameter int HIT_BIT  = 22,
   localparam int KEEP_W  = NCH + 1
) (
   input  csr_cmd_t          cmd_i,
   input  logic [XLEN-1:0]   rs1_i,
   input  logic [IMM_W-1:0]  uimm_i,
   input  logic [XLEN-1:0]   old_i,
   output logic [XLEN-1:0]   result_o,
   output logic [KEEP_W-1:0] keep_o
);

   logic [XLEN-1:0] imm_ext;
   logic [XLEN-1:0] operand;
   logic [XLEN-1:0] mask;

   // zero-extend the immediate; variant picked by the widths
   generate
      if (XLEN > IMM_W) begin : g_pad
         assign imm_ext = {{(XLEN-IMM_W){1'b0}}, uimm_i};
      end else begin : g_nopad
         assign imm_ext = uimm_i[XLEN-1:0];
      end
   endgenerate

   assign operand = cmd_i.src_imm ? imm_ext : rs1_i;
   // the mask is formed apart from the combined result
   assign mask    = (cmd_i.op == OP_CLEAR) ? ~operand : operand;

   always_comb begin
      unique case (cmd_i.op)
         OP_SET:   result_o = old_i | mask;
         OP_CLEAR: result_o = old_i & mask;
         default:  result_o = mask;
      endcase
   end

   // per-flag "leave alone" bits: hit flag on top, pending flags below
   assign keep_o = {mask[HIT_BIT], mask[PEND_LSB +: NCH]};

   always_comb begin
      if (cmd_i.op == OP_SET)
         assert_set_covers_R3: assert ((result_o & operand) == operand);
      if (cmd_i.op == OP_CLEAR)
         assert_clear_removes_R3: assert ((result_o & operand) == '0);
   end

endmodule

// File: rtl/pend_csr_stage.sv
module pend_csr_stage #(
   parameter int          ADDR_W    = 12,
   parameter int          KEEP_W    = 17,
   parameter logic [11:0] PEND_ADDR = 12'h344,
   parameter logic [11:0] TRIG_ADDR = 12'h7A1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic              illegal_i,
   input  logic              lowers_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [KEEP_W-1:0] keep_i,
   output logic              upd_pend_o,
   output logic              upd_trig_o,
   output logic [KEEP_W-1:0] keep_q_o
);

   logic              we_q;
   logic              lowers_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         we_q     <= 1'b0;
         lowers_q <= 1'b0;
         addr_q   <= '0;
         keep_q_o <= '1;
      end else begin
         we_q     <= we_i & ~illegal_i;
         lowers_q <= lowers_i;
         addr_q   <= addr_i;
         keep_q_o <= keep_i;
      end
   end

   assign upd_pend_o = we_q & lowers_q & (addr_q == PEND_ADDR[ADDR_W-1:0]);
   assign upd_trig_o = we_q & lowers_q & (addr_q == TRIG_ADDR[ADDR_W-1:0]);

   assert_illegal_suppress_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && illegal_i) |=> (!upd_pend_o && !upd_trig_o));

   assert_set_no_update_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lowers_i |=> (!upd_pend_o && !upd_trig_o));

endmodule

// File: rtl/pend_csr_flag.sv
module pend_csr_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic upd_i,
   input  logic keep_i,
   output logic q_o
);

   // hardware set outranks a software clear in the same cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         q_o <= 1'b0;
      else if (set_i)
         q_o <= 1'b1;
      else if (upd_i && !keep_i)
         q_o <= 1'b0;
   end

   assert_req_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> q_o);

   assert_no_sw_raise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i && !q_o) |=> !q_o);

   assert_keep_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o && (keep_i || !upd_i)) |=> q_o);

endmodule

// File: rtl/pend_csr_unit.sv
module pend_csr_unit
   import pend_csr_pkg::*;
#(
   parameter int          XLEN      = 32,
   parameter int          ADDR_W    = 12,
   parameter int          IMM_W     = 5,
   parameter int          NCH       = 16,
   parameter int          PEND_LSB  = 16,
   parameter int          HIT_BIT   = 22,
   parameter logic [11:0] PEND_ADDR = 12'h344,
   parameter logic [11:0] TRIG_ADDR = 12'h7A1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              csr_we_i,
   input  logic              illegal_i,
   input  logic [2:0]        cmd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [XLEN-1:0]   rs1_i,
   input  logic [IMM_W-1:0]  uimm_i,
   input  logic [NCH-1:0]    irq_req_i,
   input  logic              bp_match_i,
   input  logic              bp_exc_i,
   output logic [XLEN-1:0]   rdata_o,
   output logic [XLEN-1:0]   wdata_o,
   output logic [NCH-1:0]    pend_o,
   output logic              hit_o
);

   localparam int KEEP_W = NCH + 1;

   // elaboration-time parameter checks
   generate
      if (PEND_LSB + NCH > XLEN) begin : g_bad_range
         $error("pending field exceeds register width");
      end
      if (HIT_BIT >= XLEN) begin : g_bad_hit
         $error("hit bit outside register");
      end
      if (IMM_W > XLEN) begin : g_bad_imm
         $error("immediate wider than register");
      end
      if (ADDR_W > 12) begin : g_bad_addr
         $error("address width over 12 bits");
      end
      if (PEND_ADDR == TRIG_ADDR) begin : g_bad_map
         $error("register addresses collide");
      end
   endgenerate

   csr_cmd_t          cmd_s;
   logic [XLEN-1:0]   pend_word;
   logic [XLEN-1:0]   trig_word;
   logic [KEEP_W-1:0] keep_w;
   logic [KEEP_W-1:0] keep_q;
   logic              upd_pend;
   logic              upd_trig;

   assign cmd_s = csr_cmd_t'(cmd_i);

   always_comb begin
      pend_word                   = '0;
      pend_word[PEND_LSB +: NCH]  = pend_o;
      trig_word                   = '0;
      trig_word[HIT_BIT]          = hit_o;
   end

   always_comb begin
      if (addr_i == PEND_ADDR[ADDR_W-1:0])
         rdata_o = pend_word;
      else if (addr_i == TRIG_ADDR[ADDR_W-1:0])
         rdata_o = trig_word;
      else
         rdata_o = '0;
   end

   pend_csr_alu #(
      .XLEN(XLEN), .IMM_W(IMM_W), .PEND_LSB(PEND_LSB), .NCH(NCH), .HIT_BIT(HIT_BIT)
   ) u_alu (
      .cmd_i   (cmd_s),
      .rs1_i   (rs1_i),
      .uimm_i  (uimm_i),
      .old_i   (rdata_o),
      .result_o(wdata_o),
      .keep_o  (keep_w)
   );

   pend_csr_stage #(
      .ADDR_W(ADDR_W), .KEEP_W(KEEP_W), .PEND_ADDR(PEND_ADDR), .TRIG_ADDR(TRIG_ADDR)
   ) u_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (csr_we_i),
      .illegal_i (illegal_i),
      .lowers_i  (op_lowers(cmd_s.op)),
      .addr_i    (addr_i),
      .keep_i    (keep_w),
      .upd_pend_o(upd_pend),
      .upd_trig_o(upd_trig),
      .keep_q_o  (keep_q)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_chan
         pend_csr_flag u_flag (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .set_i (irq_req_i[i]),
            .upd_i (upd_pend),
            .keep_i(keep_q[i]),
            .q_o   (pend_o[i])
         );
      end
   endgenerate

   pend_csr_flag u_hit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (bp_match_i & bp_exc_i),
      .upd_i (upd_trig),
      .keep_i(keep_q[NCH]),
      .q_o   (hit_o)
   );

   assert_hit_needs_both_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hit_o && !(bp_match_i && bp_exc_i)) |=> !hit_o);

endmodule

// File: tb/pend_csr_unit_bench.sv
module pend_csr_unit_bench;

   localparam logic [11:0] PA = 12'h344;
   localparam logic [11:0] TA = 12'h7A1;
   localparam logic [11:0] XA = 12'h300;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic        ill = 1'b0;
   logic [2:0]  cmd = 3'b000;
   logic [11:0] addr = 12'h000;
   logic [31:0] rs1 = 32'h0;
   logic [4:0]  uimm = 5'h0;
   logic [15:0] req = 16'h0;
   logic        bpm = 1'b0;
   logic        bpe = 1'b0;
   logic [31:0] rdata;
   logic [31:0] wdata;
   logic [15:0] pend;
   logic        hit;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [15:0] exp_pend = 16'h0;
   logic        exp_hit = 1'b0;

   always #4 clk = ~clk;

   pend_csr_unit u_pend_csr_unit (
      .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .illegal_i(ill), .cmd_i(cmd),
      .addr_i(addr), .rs1_i(rs1), .uimm_i(uimm), .irq_req_i(req),
      .bp_match_i(bpm), .bp_exc_i(bpe), .rdata_o(rdata), .wdata_o(wdata),
      .pend_o(pend), .hit_o(hit)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] opnd(input logic [2:0] c, input logic [31:0] r, input logic [4:0] i);
      return c[2] ? {27'h0, i} : r;
   endfunction

   function automatic logic [31:0] mk(input logic [2:0] c, input logic [31:0] r, input logic [4:0] i);
      return (c[1:0] == 2'b11) ? ~opnd(c, r, i) : opnd(c, r, i);
   endfunction

   function automatic logic [31:0] old_of(input logic [11:0] a);
      if (a == PA) return {exp_pend, 16'h0};
      if (a == TA) return {9'h0, exp_hit, 22'h0};
      return 32'h0;
   endfunction

   function automatic logic [31:0] res_of(input logic [2:0] c, input logic [11:0] a,
                                          input logic [31:0] r, input logic [4:0] i);
      case (c[1:0])
         2'b10:   return old_of(a) | mk(c, r, i);
         2'b11:   return old_of(a) & mk(c, r, i);
         default: return mk(c, r, i);
      endcase
   endfunction

   // one access: wdata checked while presented, flags settle two edges on
   task automatic access(input logic [2:0] c, input logic [11:0] a, input logic [31:0] r,
                         input logic [4:0] i, input logic il, input string tag);
      logic [31:0] m;
      @(negedge clk);
      we = 1'b1; ill = il; cmd = c; addr = a; rs1 = r; uimm = i;
      #1;
      chk({tag, " R3 wdata"}, wdata, res_of(c, a, r, i));
      m = mk(c, r, i);
      @(negedge clk);
      we = 1'b0; ill = 1'b0;
      @(negedge clk);
      if (!il && c[0]) begin
         if (a == PA) exp_pend = exp_pend & m[31:16];
         if (a == TA) exp_hit  = exp_hit & m[22];
      end
   endtask

   task automatic raise(input logic [15:0] r);
      @(negedge clk);
      req = r;
      @(negedge clk);
      req = 16'h0;
      exp_pend = exp_pend | r;
   endtask

   task automatic fire_hit();
      @(negedge clk);
      bpm = 1'b1; bpe = 1'b1;
      @(negedge clk);
      bpm = 1'b0; bpe = 1'b0;
      exp_hit = 1'b1;
   endtask

   task automatic look(input string tag);
      chk({tag, " pend"}, {16'h0, pend}, {16'h0, exp_pend});
      chk({tag, " hit"}, {31'h0, hit}, {31'h0, exp_hit});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      addr = PA; #1;
      chk("R1 rdata pend", rdata, 32'h0);
      look("R1");
      rst_n = 1'b1;

      // R4 requests set flags and stay
      raise(16'hA5C3);
      look("R4 set");
      repeat (5) @(negedge clk);
      look("R4 sticky");
      addr = PA; #1;
      chk("R4 R10 rdata", rdata, {exp_pend, 16'h0});

      // write ones, set ones, clear one bit, write zero
      access(3'b001, PA, 32'hFFFF_FFFF, 5'd0, 1'b0, "R5 w1");
      look("R5 write ones");
      access(3'b010, PA, 32'hFFFF_FFFF, 5'd0, 1'b0, "R6 s1");
      look("R6 set ones");
      access(3'b011, PA, 32'h1 << 17, 5'd0, 1'b0, "R7 c1");
      chk("R7 single clear", {16'h0, pend}, {16'h0, 16'hA5C1});
      look("R7 model");
      access(3'b001, PA, 32'h0, 5'd0, 1'b0, "R5 w0");
      chk("R5 write zero", {16'h0, pend}, 32'h0);

      // near-exhaustive sweep of command codes and patterns
      for (int c = 0; c < 8; c++) begin
         for (int k = 0; k < 6; k++) begin
            logic [31:0] r;
            access(3'b001, PA, 32'h0, 5'd0, 1'b0, "R5 prep");
            raise(16'hFFFF ^ (16'h1357 * k[15:0]));
            r = (32'h9E37_79B9 * (k + 1)) ^ (32'h0001_0000 << k);
            access(c[2:0], PA, r, 5'(k * 7), 1'b0, c[0] ? (c[1] ? "R7 sweep" : "R5 sweep")
                                                        : "R6 sweep");
            look(c[2] ? "R2 sweep" : (c[0] ? (c[1] ? "R7 sweep" : "R5 sweep") : "R6 sweep"));
            addr = PA; #1;
            chk("R10 low half", {16'h0, rdata[15:0]}, 32'h0);
         end
      end

      // R2 immediate forms
      raise(16'h3C3C);
      access(3'b111, PA, 32'h0, 5'h1F, 1'b0, "R2 ci");
      chk("R2 imm clear keeps", {16'h0, pend}, {16'h0, exp_pend});
      access(3'b101, PA, 32'hFFFF_FFFF, 5'h1F, 1'b0, "R2 wi");
      chk("R2 imm write clears", {16'h0, pend}, 32'h0);

      // R8 request wins over clear in the same cycle
      raise(16'h00F0);
      @(negedge clk);
      we = 1'b1; cmd = 3'b001; addr = PA; rs1 = 32'h0;
      @(negedge clk);
      we = 1'b0; req = 16'h0020;
      @(negedge clk);
      req = 16'h0;
      exp_pend = 16'h0020;
      chk("R8 req beats clear", {16'h0, pend}, 32'h0000_0020);

      // R9 illegal suppresses
      raise(16'h8001);
      access(3'b001, PA, 32'h0, 5'd0, 1'b1, "R9 ill");
      look("R9 illegal");
      chk("R9 kept", {16'h0, pend}, 32'h0000_8021);

      // R10 other address
      access(3'b001, XA, 32'h0, 5'd0, 1'b0, "R10 xa");
      look("R10 other addr");
      addr = XA; #1;
      chk("R10 rdata other", rdata, 32'h0);

      // R11 hit flag
      @(negedge clk); bpm = 1'b1;
      @(negedge clk); bpm = 1'b0; bpe = 1'b1;
      @(negedge clk); bpe = 1'b0;
      look("R11 one input");
      fire_hit();
      look("R11 fired");
      addr = TA; #1;
      chk("R11 rdata", rdata, 32'h0040_0000);
      access(3'b001, TA, 32'hFFFF_FFFF, 5'd0, 1'b0, "R11 w1");
      look("R11 write ones");
      access(3'b110, TA, 32'h0, 5'h1F, 1'b0, "R11 si");
      look("R11 set");
      access(3'b001, PA, 32'h0, 5'd0, 1'b0, "R11 pa");
      look("R11 pend clear leaves hit");
      access(3'b011, TA, 32'h0040_0000, 5'd0, 1'b0, "R11 c");
      chk("R11 cleared", {31'h0, hit}, 32'h0);
      fire_hit();
      @(negedge clk);
      we = 1'b1; cmd = 3'b001; addr = TA; rs1 = 32'h0;
      @(negedge clk);
      we = 1'b0; bpm = 1'b1; bpe = 1'b1;
      @(negedge clk);
      bpm = 1'b0; bpe = 1'b0;
      chk("R11 set beats clear", {31'h0, hit}, 32'h1);
      access(3'b001, TA, 32'h0, 5'd0, 1'b0, "R11 w0");
      look("R11 write zero");

      // R1 reset mid-run
      raise(16'hFFFF);
      fire_hit();
      rst_n = 1'b0;
      exp_pend = 16'h0; exp_hit = 1'b0;
      #1;
      look("R1 async reset");
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule